// File: doc/BRIEF.md
# USB Slave-FIFO Crossbar Controller

This block lets several FPGA-side streams share one parallel slave-FIFO bus toward an external USB peripheral controller with four endpoint FIFOs. Each stream is bound to one endpoint. A parameter mask marks each endpoint as IN (the FPGA writes toward the host) or OUT (the FPGA reads what the host sent). The controller serves one endpoint at a time. It drives that endpoint's two-bit address, then moves words with the read, write, output-enable and packet-end strobes.

The flags from the external controller arrive late, so the block does not trust them where it can avoid it. For IN endpoints it counts the words written into each endpoint buffer and stops at capacity. For OUT endpoints every word it reads goes into a small tagged skid buffer. The buffer hands the words to the right stream, so a stalled stream never loses a word. Switching endpoints always follows a fixed walk: pick, drive the address, let the flags settle, transfer, pick again.

Top module: `usb_fifo_xbar`

## Requirements
- R1: While reset is held, fifo_addr is 0, and rd_stb, wr_stb, pkt_stb, oe_stb, dq_oe, every in_ready bit and every out_valid bit are 0.
- R2: rd_stb and wr_stb are never high in the same cycle. Every strobe acts on the single endpoint shown on fifo_addr.
- R3: From idle, the controller goes through pick, address drive, two settle cycles and then transfer. Work first visible at clock edge k puts the new address on fifo_addr after edge k and the first strobe after edge k+3. Every transfer ends by returning to pick.
- R4: The pick is round-robin among endpoints with work. The search starts at the endpoint after the one served last, and after reset it starts at endpoint 0.
- R5: An IN endpoint accepts at most CAP_WORDS words (512 bytes; 512 words at 8 bits) between packet commits. At capacity its in_ready stays low.
- R6: A write of a word marked in_last is followed in the very next cycle by pkt_stb at the same address. A flush_req pulse on an IN endpoint makes it commit with pkt_stb even when it is at capacity. Every pkt_stb clears that endpoint's word count.
- R7: For an OUT endpoint, rd_stb is issued only while ep_empty for the selected endpoint is low and the skid buffer has room. Every word read reaches out_data of its own stream in order, even when out_ready drops. With a depth of 4, at most 4 words are read ahead of a stalled stream.
- R8: oe_stb is high only in cycles with a read from an OUT endpoint. It is never high together with wr_stb.
- R9: dq_oe is high only while an IN transfer is active and never during a read. Each written word on dq_o equals the word its stream offered.
- R10: While slv_cs is low, none of rd_stb, wr_stb or pkt_stb is asserted, and no stream word is consumed.
- R11: The words of each IN stream appear on the bus in stream order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | NUM_EP*DW | Per-endpoint IN stream words, lane i at bits i*DW |
| in_valid | input | NUM_EP | IN stream word offered |
| in_last | input | NUM_EP | Offered word closes a packet |
| in_ready | output | NUM_EP | IN stream word accepted this cycle |
| flush_req | input | NUM_EP | Pulse: commit the IN endpoint's partial packet |
| out_data | output | DW | Head word of the skid buffer |
| out_valid | output | NUM_EP | Head word belongs to OUT stream i |
| out_ready | input | NUM_EP | OUT stream i can take a word |
| slv_cs | input | 1 | Bus select; strobes only act while high |
| ep_empty | input | NUM_EP | Per-endpoint empty flag from the device (1 = empty) |
| fifo_addr | output | IDX_W | Selected endpoint address |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| oe_stb | output | 1 | Device output enable |
| pkt_stb | output | 1 | Packet-end strobe |
| dq_i | input | DW | Data from the device |
| dq_o | output | DW | Data toward the device |
| dq_oe | output | 1 | FPGA drives the data bus |

## Verification
The bench measures the settle timing after an endpoint change. A design that skipped or added a settle cycle would move the first write away from its fixed slot. It gives two endpoints work at once right after serving the lower one. A fixed-priority picker would serve the lower one again instead of rotating. It holds an OUT stream stalled with words waiting and expects exactly the skid depth to be read ahead. A design that ignored its skid room would read too far and lose words, and one that reset the stream on a switch would reorder them. It pushes 600 words without a packet end into one IN endpoint, expects the writes to stop at 512 until a flush commits, and drops slv_cs to show that no strobe or stream word leaks through.

// File: rtl/usb_fifo_xbar_pkg.sv
package usb_fifo_xbar_pkg;
    typedef enum logic [2:0] {
        ST_SWITCH,
        ST_DRIVE,
        ST_SETUP,
        ST_IN_XFER,
        ST_OUT_XFER
    } xfer_state_e;
endpackage

// File: rtl/usb_fifo_rr_pick.sv
// Round-robin selector: first requester after the last served index.
module usb_fifo_rr_pick #(
    parameter int NUM_EP = 4,
    localparam int IDX_W = $clog2(NUM_EP)
) (
    input  logic [NUM_EP-1:0] req,
    input  logic [IDX_W-1:0]  last_idx,
    output logic              gnt_vld,
    output logic [IDX_W-1:0]  gnt_idx
);
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int k = NUM_EP; k >= 1; k--) begin
            int idx;
            idx = (int'(last_idx) + k) % NUM_EP;
            if (req[idx]) begin
                gnt_vld = 1'b1;
                gnt_idx = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/usb_fifo_lvl.sv
// Per-endpoint word counters for IN buffers; saturate at capacity.
module usb_fifo_lvl #(
    parameter int NUM_EP    = 4,
    parameter int CAP_WORDS = 512,
    localparam int CNT_W    = $clog2(CAP_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] inc,
    input  logic [NUM_EP-1:0] clr,
    output logic [NUM_EP-1:0] at_cap
);
    for (genvar i = 0; i < NUM_EP; i++) begin : g_lane
        logic [CNT_W-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (clr[i])
                cnt_d = '0;
            else if (inc[i] && cnt_q < CNT_W'(CAP_WORDS))
                cnt_d = cnt_q + 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign at_cap[i] = (cnt_q == CNT_W'(CAP_WORDS));

        // R5: level never passes the buffer capacity
        p_lvl_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_W'(CAP_WORDS));
        // R6: a commit empties the count
        p_lvl_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] |=> cnt_q == '0);
    end
endmodule

// File: rtl/usb_fifo_skid.sv
// Tagged skid buffer catching OUT reads until the owning stream takes them.
module usb_fifo_skid #(
    parameter int DW     = 8,
    parameter int TAG_W  = 2,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic             full,
    output logic             head_vld,
    output logic [TAG_W-1:0] head_tag,
    output logic [DW-1:0]    head_data
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } skid_regs_t;

    skid_regs_t s_d, s_q;
    logic [DW-1:0]    mem_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = nxt(s_q.wp);
        if (pop)  s_d.rp = nxt(s_q.rp);
        s_d.cnt = s_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[s_q.wp] <= push_data;
            tag_q[s_q.wp] <= push_tag;
        end
    end

    assign full      = (s_q.cnt == CNT_W'(DEPTH));
    assign head_vld  = (s_q.cnt != '0);
    assign head_tag  = tag_q[s_q.rp];
    assign head_data = mem_q[s_q.rp];

    // R7: a read is never issued into a full skid buffer
    p_skid_no_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7: nothing leaves an empty buffer
    p_skid_no_udf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_vld);
endmodule

// File: rtl/usb_fifo_xbar.sv
module usb_fifo_xbar
    import usb_fifo_xbar_pkg::*;
#(
    parameter int          NUM_EP     = 4,
    parameter int          DW         = 8,
    parameter int          BUF_BYTES  = 512,
    parameter int          SKID_DEPTH = 4,
    parameter int          SETUP_CYC  = 2,
    parameter logic [NUM_EP-1:0] IN_MASK = 4'b1100,
    localparam int IDX_W     = $clog2(NUM_EP),
    localparam int CAP_WORDS = BUF_BYTES / (DW / 8),
    localparam int WT_W      = $clog2(SETUP_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EP*DW-1:0] in_data,
    input  logic [NUM_EP-1:0]    in_valid,
    input  logic [NUM_EP-1:0]    in_last,
    output logic [NUM_EP-1:0]    in_ready,
    input  logic [NUM_EP-1:0]    flush_req,
    output logic [DW-1:0]        out_data,
    output logic [NUM_EP-1:0]    out_valid,
    input  logic [NUM_EP-1:0]    out_ready,
    input  logic                 slv_cs,
    input  logic [NUM_EP-1:0]    ep_empty,
    output logic [IDX_W-1:0]     fifo_addr,
    output logic                 rd_stb,
    output logic                 wr_stb,
    output logic                 oe_stb,
    output logic                 pkt_stb,
    input  logic [DW-1:0]        dq_i,
    output logic [DW-1:0]        dq_o,
    output logic                 dq_oe
);
    typedef struct packed {
        xfer_state_e       state;
        logic [IDX_W-1:0]  sel;
        logic [IDX_W-1:0]  last_srv;
        logic [WT_W-1:0]   wait_cnt;
        logic              pkt_pend;
        logic [NUM_EP-1:0] flush_pend;
    } xbar_regs_t;

    xbar_regs_t r_d, r_q;

    logic [NUM_EP-1:0] work, at_cap, lvl_inc, lvl_clr;
    logic              gnt_vld, skid_full, skid_vld, skid_pop;
    logic [IDX_W-1:0]  gnt_idx, skid_tag;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_work
        if (IN_MASK[i]) begin : g_in
            assign work[i] = (in_valid[i] && !at_cap[i]) || r_q.flush_pend[i];
        end else begin : g_out
            assign work[i] = !ep_empty[i] && out_ready[i] && !skid_full;
        end
    end

    usb_fifo_rr_pick #(.NUM_EP(NUM_EP)) u_pick (
        .req(work), .last_idx(r_q.last_srv), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
    );

    usb_fifo_lvl #(.NUM_EP(NUM_EP), .CAP_WORDS(CAP_WORDS)) u_lvl (
        .clk(clk), .rst_n(rst_n), .inc(lvl_inc), .clr(lvl_clr), .at_cap(at_cap)
    );

    usb_fifo_skid #(.DW(DW), .TAG_W(IDX_W), .DEPTH(SKID_DEPTH)) u_skid (
        .clk(clk), .rst_n(rst_n), .push(rd_stb), .push_tag(r_q.sel),
        .push_data(dq_i), .pop(skid_pop), .full(skid_full),
        .head_vld(skid_vld), .head_tag(skid_tag), .head_data(out_data)
    );

    assign skid_pop = skid_vld && out_ready[skid_tag];
    always_comb begin
        out_valid = '0;
        out_valid[skid_tag] = skid_vld;
    end

    assign fifo_addr = r_q.sel;
    assign dq_o      = in_data[r_q.sel*DW +: DW];

    always_comb begin
        r_d        = r_q;
        rd_stb     = 1'b0;
        wr_stb     = 1'b0;
        oe_stb     = 1'b0;
        pkt_stb    = 1'b0;
        dq_oe      = 1'b0;
        in_ready   = '0;
        lvl_inc    = '0;
        lvl_clr    = '0;
        r_d.flush_pend = r_q.flush_pend | (flush_req & IN_MASK);

        unique case (r_q.state)
            ST_SWITCH: begin
                if (gnt_vld) begin
                    r_d.sel      = gnt_idx;
                    r_d.last_srv = gnt_idx;
                    r_d.state    = ST_DRIVE;
                end
            end
            ST_DRIVE: begin
                r_d.wait_cnt = '0;
                r_d.state    = ST_SETUP;
            end
            ST_SETUP: begin
                if (r_q.wait_cnt == WT_W'(SETUP_CYC - 1))
                    r_d.state = IN_MASK[r_q.sel] ? ST_IN_XFER : ST_OUT_XFER;
                else
                    r_d.wait_cnt = r_q.wait_cnt + 1'b1;
            end
            ST_IN_XFER: begin
                dq_oe = 1'b1;
                if (r_q.pkt_pend) begin
                    if (slv_cs) begin
                        pkt_stb               = 1'b1;
                        lvl_clr[r_q.sel]      = 1'b1;
                        r_d.pkt_pend          = 1'b0;
                        r_d.flush_pend[r_q.sel] = 1'b0;
                        r_d.state             = ST_SWITCH;
                    end
                end else if (!slv_cs) begin
                    r_d.state = ST_SWITCH;
                end else if (in_valid[r_q.sel] && !at_cap[r_q.sel]) begin
                    wr_stb            = 1'b1;
                    in_ready[r_q.sel] = 1'b1;
                    lvl_inc[r_q.sel]  = 1'b1;
                    r_d.pkt_pend      = in_last[r_q.sel];
                end else if (r_q.flush_pend[r_q.sel]) begin
                    r_d.pkt_pend = 1'b1;
                end else begin
                    r_d.state = ST_SWITCH;
                end
            end
            ST_OUT_XFER: begin
                if (slv_cs && !ep_empty[r_q.sel] && !skid_full) begin
                    rd_stb = 1'b1;
                    oe_stb = 1'b1;
                end else begin
                    r_d.state = ST_SWITCH;
                end
            end
            default: r_d.state = ST_SWITCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.state    <= ST_SWITCH;
            r_q.last_srv <= IDX_W'(NUM_EP - 1);
        end else begin
            r_q <= r_d;
        end
    end

    // R2: one direction per cycle
    p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> !wr_stb);
    // R8: device output enable never overlaps a write
    p_oe_not_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !oe_stb);
    // R9: FPGA never drives the bus while the device is enabled to drive it
    p_dq_oe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !oe_stb && !rd_stb);
    // R10: strobes gated by bus select
    p_cs_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_cs |-> !(rd_stb || wr_stb || pkt_stb));
    // R3: address drive is always followed by settling
    p_drive_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state == ST_DRIVE |=> r_q.state == ST_SETUP);
    // R3: address stays put from drive until the walk returns to pick
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state != ST_SWITCH |=> $stable(fifo_addr));
    // R6: packet end follows a last write at the same address
    p_pkt_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && in_last[fifo_addr] && slv_cs |=> !slv_cs || (pkt_stb && $stable(fifo_addr)));
endmodule

// File: tb/usb_fifo_xbar_tb.sv
module usb_fifo_xbar_tb;
    localparam int N = 4, DW = 8, SKID = 4, CAP = 512;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N*DW-1:0] in_data;
    logic [N-1:0] in_valid, in_last, in_ready, flush_req, out_valid, out_ready, ep_empty;
    logic [DW-1:0] out_data, dq_i, dq_o;
    logic slv_cs, rd_stb, wr_stb, oe_stb, pkt_stb, dq_oe;
    logic [1:0] fifo_addr;

    always #2.5 clk = ~clk;

    usb_fifo_xbar u_dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .flush_req(flush_req),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .slv_cs(slv_cs), .ep_empty(ep_empty), .fifo_addr(fifo_addr),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .oe_stb(oe_stb), .pkt_stb(pkt_stb),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] src_d [N][1024];
    bit         src_l [N][1024];
    int src_n[N], src_i[N], dev_n[N], dev_i[N], rcv_i[N], n_wr[N], n_pkt[N];
    logic [7:0] dev_d [N][1024];
    bit tk[N], flush_arm[N];
    bit rd_ev, prev_wr_last, cs_drv = 1'b1;
    int rd_ep, prev_addr, vpct = 100, rpct = 100, first_wr = -1, steps = 0;
    logic [N-1:0] rdy_mask = '1, flush_drv = '0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic add_in(input int ep, input int n, input bit rnd_last);
        for (int k = 0; k < n; k++) begin
            src_d[ep][src_n[ep]] = 8'($urandom);
            src_l[ep][src_n[ep]] = (k == n - 1) || (rnd_last && ($urandom % 16 == 0));
            src_n[ep]++;
        end
    endtask

    task automatic add_out(input int ep, input int n);
        for (int k = 0; k < n; k++) begin
            dev_d[ep][dev_n[ep]] = 8'($urandom);
            dev_n[ep]++;
        end
    endtask

    task automatic step();
        int a;
        @(negedge clk);
        steps++;
        for (int i = 0; i < N; i++) if (tk[i]) src_i[i]++;
        if (rd_ev) dev_i[rd_ep]++;
        for (int i = 0; i < N; i++) begin
            in_valid[i] = (src_i[i] < src_n[i]) && (($urandom % 100) < vpct);
            in_data[i*DW +: DW] = src_d[i][src_i[i]];
            in_last[i] = src_l[i][src_i[i]];
            out_ready[i] = rdy_mask[i] && (($urandom % 100) < rpct);
            ep_empty[i] = dev_i[i] >= dev_n[i];
        end
        a = int'(fifo_addr);
        dq_i = (dev_i[a] < dev_n[a]) ? dev_d[a][dev_i[a]] : 8'hEE;
        slv_cs = cs_drv;
        flush_req = flush_drv;
        #1;
        a = int'(fifo_addr);
        for (int i = 0; i < N; i++) tk[i] = in_valid[i] && in_ready[i];
        if (wr_stb) begin
            if (first_wr < 0) first_wr = a;
            chk(in_ready[a], "R11", "write without stream handshake", 0, 1);
            chk(dq_o == src_d[a][src_i[a]], "R11", "written word", int'(dq_o), int'(src_d[a][src_i[a]]));
            chk(dq_oe && !oe_stb, "R9", "bus drive during write", int'(dq_oe), 1);
            chk(!rd_stb, "R2", "read with write", int'(rd_stb), 0);
            n_wr[a]++;
        end
        rd_ev = rd_stb;
        rd_ep = a;
        if (rd_stb) begin
            chk(!ep_empty[a], "R7", "read of empty endpoint", int'(ep_empty[a]), 0);
            chk(oe_stb && !dq_oe, "R8", "oe during read", int'(oe_stb), 1);
        end
        if (oe_stb && !rd_stb) chk(0, "R8", "oe without read", 1, 0);
        for (int i = 0; i < N; i++)
            if (out_valid[i] && out_ready[i]) begin
                chk(out_data == dev_d[i][rcv_i[i]], "R7", "out stream word", int'(out_data), int'(dev_d[i][rcv_i[i]]));
                rcv_i[i]++;
            end
        if (prev_wr_last) begin
            chk(pkt_stb && a == prev_addr, "R6", "packet end after last", int'(pkt_stb), 1);
            if (pkt_stb) n_pkt[a]++;
        end else if (pkt_stb) begin
            chk(flush_arm[a], "R6", "unexpected packet end", a, -1);
            flush_arm[a] = 1'b0;
            n_pkt[a]++;
        end
        if (!slv_cs && (rd_stb || wr_stb || pkt_stb))
            chk(0, "R10", "strobe with bus deselected", 1, 0);
        prev_wr_last = wr_stb && in_last[a];
        prev_addr = a;
    endtask

    function automatic bit drained();
        for (int i = 0; i < N; i++)
            if (src_i[i] + int'(tk[i]) < src_n[i] || rcv_i[i] < dev_n[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic run_idle(input string req);
        int k = 0;
        while (!drained() && k < 20000) begin step(); k++; end
        repeat (12) step();
        chk(drained(), req, "drain", k, 0);
    endtask

    initial begin
        #(150000 * 5);
        chk(0, "ALL", "watchdog expired", steps, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int k2, k5, w0;
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin
            src_n[i] = 0; src_i[i] = 0; dev_n[i] = 0; dev_i[i] = 0;
            rcv_i[i] = 0; n_wr[i] = 0; n_pkt[i] = 0; tk[i] = 0; flush_arm[i] = 0;
        end
        rd_ev = 0; prev_wr_last = 0; prev_addr = 0; rd_ep = 0;
        in_valid = '0; in_last = '0; in_data = '0; flush_req = '0;
        out_ready = '0; ep_empty = '1; dq_i = '0; slv_cs = 1'b1;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(fifo_addr == 0, "R1", "reset addr", int'(fifo_addr), 0);
        chk(!(rd_stb | wr_stb | pkt_stb | oe_stb | dq_oe), "R1", "reset strobes", 1, 0);
        chk(in_ready == 0 && out_valid == 0, "R1", "reset handshakes", int'(in_ready), 0);
        rst_n = 1'b1;

        // R3: address after one edge, first write after four
        add_in(2, 1, 0);
        k2 = -1; k5 = -1;
        for (int s = 1; s <= 12; s++) begin
            step();
            if (k2 < 0 && fifo_addr == 2) k2 = s;
            if (k5 < 0 && wr_stb) k5 = s;
        end
        chk(k2 == 2, "R3", "address drive step", k2, 2);
        chk(k5 == 5, "R3", "first write step", k5, 5);
        run_idle("R3");

        // R4: rotation past the last served endpoint
        add_in(2, 1, 0); add_in(3, 1, 0);
        first_wr = -1;
        run_idle("R4");
        chk(first_wr == 3, "R4", "round-robin first grant", first_wr, 3);

        // R7: stalled OUT stream reads exactly the skid depth ahead
        add_out(0, 10);
        rdy_mask = 4'b0001;
        step();
        rdy_mask = 4'b0000;
        repeat (30) step();
        chk(dev_i[0] == SKID, "R7", "reads ahead of stall", dev_i[0], SKID);
        chk(rcv_i[0] == 0, "R7", "no delivery while stalled", rcv_i[0], 0);
        rdy_mask = '1;
        run_idle("R7");
        chk(rcv_i[0] == 10, "R7", "all words delivered", rcv_i[0], 10);

        // R10: deselected bus blocks every strobe
        w0 = src_i[3];
        cs_drv = 1'b0;
        add_in(3, 5, 0);
        repeat (30) step();
        chk(src_i[3] == w0 && !tk[3], "R10", "words consumed while deselected", src_i[3] - w0, 0);
        cs_drv = 1'b1;
        run_idle("R10");
        chk(n_pkt[3] == 2, "R10", "packet after reselect", n_pkt[3], 2);

        // R5 and R6: capacity stop, flush commit
        w0 = n_wr[3];
        add_in(3, 600, 0);
        repeat (800) step();
        chk(n_wr[3] - w0 == CAP, "R5", "words before commit", n_wr[3] - w0, CAP);
        chk(in_ready[3] == 0, "R5", "ready at capacity", int'(in_ready[3]), 0);
        chk(n_pkt[3] == 2, "R6", "no packet end before flush", n_pkt[3], 2);
        flush_arm[3] = 1'b1;
        flush_drv = 4'b1000;
        step();
        flush_drv = '0;
        run_idle("R6");
        chk(n_pkt[3] == 4, "R6", "flush plus last commits", n_pkt[3], 4);
        chk(n_wr[3] - w0 == 600, "R5", "words after flush", n_wr[3] - w0, 600);

        // R2, R6, R7, R11: random mixed traffic
        vpct = 70; rpct = 60;
        add_in(2, 200, 1); add_in(3, 200, 1);
        add_out(0, 150); add_out(1, 150);
        run_idle("R11");
        chk(n_wr[2] == src_n[2], "R11", "ep2 words written", n_wr[2], src_n[2]);
        chk(n_wr[3] == src_n[3], "R11", "ep3 words written", n_wr[3], src_n[3]);
        chk(rcv_i[1] == dev_n[1], "R7", "ep1 words delivered", rcv_i[1], dev_n[1]);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule